// File: doc/BRIEF.md
# Interrupt Level Mask Controller

This block decides, one clock at a time, whether an incoming interrupt or trap is taken. It holds a 5-bit current level mask. A request with a 5-bit priority level is taken only when that level is numerically lower than the mask, so a smaller level number means a more urgent request. When a request is taken, the mask is loaded with that request's level. After that, only more urgent requests can nest on top of it.

The sources are several maskable requests, each with its own programmed level, gated by a global enable. There is also a fixed-level non-maskable request at level 15 and a fixed-level step/break trap at level 4. A separate class of traps skips the level comparison entirely and leaves the mask untouched. Examples of that class are undefined operations, coprocessor faults and software interrupt instructions. Software can rewrite the mask through a write port. Once the mask sits in the upper half (16–31), a write can never drop it into the lower half, which is reserved for system use.

All results are registered. A decision made on the inputs of one cycle shows up on the outputs after the next rising clock edge. Vector fetch, context stacking and exception sequencing are handled elsewhere.

Top module: `ilm_gate`

## Requirements
- R1: While reset is held and right after its release, the mask output reads 15, and both `ackPulse` and `bypassAck` are 0.
- R2: A maskable request is taken only when three things hold: its valid bit is set, `intEnable` is 1, and its level is below the mask. A taken request raises `ackPulse` for one cycle, with `ackKind` = 0, `ackLevel` = its level and `ackId` = its index.
- R3: Among eligible maskable requests, the lowest level wins. When levels are equal, the lowest index wins.
- R4: A maskable request programmed to level 31 is never taken, whatever the mask and enable.
- R5: The non-maskable request is taken at level 15 whenever the mask is above 15, even with `intEnable` at 0. It reports `ackKind` = 1 and wins over any maskable request.
- R6: The step/break trap is taken at level 4 whenever the mask is above 4, with no regard to `intEnable`. It reports `ackKind` = 2 and wins over the non-maskable and maskable requests.
- R7: When a request is taken, the mask becomes the taken level on the same edge that raises `ackPulse`.
- R8: A program write while the mask is below 16 stores the written value unchanged. While the mask is 16 or above, bit 4 of the stored value is forced to 1 (written 7 gives 23).
- R9: When a request is taken in the same cycle as a program write, the write is discarded and the mask takes the accepted level.
- R10: A bypass trap raises `bypassAck` for one cycle and leaves the mask unchanged. In that cycle no level-checked request is taken and any program write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Pending bit of each maskable request |
| reqLevel | input | NUM_REQ*5 | Programmed level of each request, request i in bits [5i+4:5i] |
| intEnable | input | 1 | Global enable for maskable requests |
| nmiReq | input | 1 | Non-maskable request, level 15 |
| stepReq | input | 1 | Step/break trap, level 4 |
| bypassReq | input | 1 | Trap class that skips the level check |
| maskWrEn | input | 1 | Program write strobe for the mask |
| maskWrData | input | 5 | Value to write into the mask |
| ackPulse | output | 1 | One-cycle strobe: a level-checked request was taken |
| ackLevel | output | 5 | Level of the taken request |
| ackKind | output | 2 | 0 maskable, 1 non-maskable, 2 step trap |
| ackId | output | ID_W | Index of the taken maskable request |
| bypassAck | output | 1 | One-cycle strobe: a bypass trap was taken |
| maskLevel | output | 5 | Current mask value |

## Verification
Every result appears exactly one rising edge after the cycle in which its inputs were presented. This covers `ackPulse`, `ackLevel`, `ackKind`, `ackId`, `bypassAck` and the updated `maskLevel`. The bench therefore applies a stimulus shortly after one edge and samples every output 1 ns after the following edge. It then clears the inputs, so each strobe is seen in its single valid cycle. Cases where a request must be refused use the same one-edge delay: the bench checks that `ackPulse` stays low and that `maskLevel` holds its earlier value at that sample point.

// File: rtl/ilm_pkg.sv
package ilm_pkg;

  localparam int LVL_W = 5;

  localparam logic [LVL_W-1:0] NMI_LEVEL     = 5'd15;
  localparam logic [LVL_W-1:0] STEP_LEVEL    = 5'd4;
  localparam logic [LVL_W-1:0] MASK_RESET    = 5'd15;
  localparam logic [LVL_W-1:0] INHIBIT_LEVEL = 5'd31;

  typedef enum logic [1:0] {
    SRC_MASKABLE = 2'd0,
    SRC_NMI      = 2'd1,
    SRC_STEP     = 2'd2
  } srcKind_e;

  typedef struct packed {
    logic     accept;
    srcKind_e src;
    logic     progWrite;
    logic     bypass;
  } ctrlStrobes_t;

endpackage

// File: rtl/ilm_control.sv
module ilm_control
  import ilm_pkg::*;
(
  input  logic         bypassReq,
  input  logic         stepReq,
  input  logic         nmiReq,
  input  logic         maskWrEn,
  input  logic         bestValid,
  input  logic         nmiOk,
  input  logic         stepOk,
  output ctrlStrobes_t ctrl
);

  logic stepTake;
  logic nmiTake;

  assign stepTake = stepReq && stepOk;
  assign nmiTake  = nmiReq && nmiOk;

  always_comb begin
    ctrl = '0;
    ctrl.src = SRC_MASKABLE;
    if (bypassReq) begin
      ctrl.bypass = 1'b1;
    end else if (stepTake) begin
      ctrl.accept = 1'b1;
      ctrl.src    = SRC_STEP;
    end else if (nmiTake) begin
      ctrl.accept = 1'b1;
      ctrl.src    = SRC_NMI;
    end else if (bestValid) begin
      ctrl.accept = 1'b1;
      ctrl.src    = SRC_MASKABLE;
    end else begin
      ctrl.progWrite = maskWrEn;
    end
  end

  always_comb begin
    assert (!(ctrl.bypass && ctrl.accept)) else $error("AST_SINGLE_ACTION"); // R10
    assert (!(ctrl.accept && ctrl.progWrite)) else $error("AST_WRITE_YIELDS"); // R9
  end

endmodule

// File: rtl/ilm_datapath.sv
module ilm_datapath
  import ilm_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ID_W    = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ*LVL_W-1:0] reqLevel,
  input  logic                     intEnable,
  input  logic [LVL_W-1:0]         maskWrData,
  input  ctrlStrobes_t             ctrl,
  output logic                     bestValid,
  output logic                     nmiOk,
  output logic                     stepOk,
  output logic                     ackPulse,
  output logic [LVL_W-1:0]         ackLevel,
  output logic [1:0]               ackKind,
  output logic [ID_W-1:0]          ackId,
  output logic                     bypassAck,
  output logic [LVL_W-1:0]         maskQ
);

  logic [LVL_W-1:0] bestLevel;
  logic [ID_W-1:0]  bestId;
  logic [NUM_REQ-1:0] eligible;
  logic [LVL_W-1:0] takeLevel;
  logic [LVL_W-1:0] writeValue;

  genvar g;
  generate
    for (g = 0; g < NUM_REQ; g++) begin : gElig
      logic [LVL_W-1:0] lvl;
      assign lvl = reqLevel[g*LVL_W +: LVL_W];
      assign eligible[g] = reqValid[g] && intEnable &&
                           (lvl != INHIBIT_LEVEL) && (lvl < maskQ);
    end
  endgenerate

  always_comb begin
    bestValid = 1'b0;
    bestLevel = INHIBIT_LEVEL;
    bestId    = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (eligible[i] && (!bestValid || reqLevel[i*LVL_W +: LVL_W] < bestLevel)) begin
        bestValid = 1'b1;
        bestLevel = reqLevel[i*LVL_W +: LVL_W];
        bestId    = ID_W'(i);
      end
    end
  end

  assign nmiOk  = NMI_LEVEL < maskQ;
  assign stepOk = STEP_LEVEL < maskQ;

  always_comb begin
    case (ctrl.src)
      SRC_STEP: takeLevel = STEP_LEVEL;
      SRC_NMI:  takeLevel = NMI_LEVEL;
      default:  takeLevel = bestLevel;
    endcase
  end

  assign writeValue = maskQ[LVL_W-1] ? {1'b1, maskWrData[LVL_W-2:0]} : maskWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= MASK_RESET;
      ackPulse  <= 1'b0;
      bypassAck <= 1'b0;
      ackLevel  <= '0;
      ackKind   <= SRC_MASKABLE;
      ackId     <= '0;
    end else begin
      ackPulse  <= 1'b0;
      bypassAck <= 1'b0;
      if (ctrl.bypass) begin
        bypassAck <= 1'b1;
      end else if (ctrl.accept) begin
        ackPulse <= 1'b1;
        ackLevel <= takeLevel;
        ackKind  <= ctrl.src;
        ackId    <= (ctrl.src == SRC_MASKABLE) ? bestId : '0;
        maskQ    <= takeLevel;
      end else if (ctrl.progWrite) begin
        maskQ <= writeValue;
      end
    end
  end

  AST_ACK_BELOW_OLD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> ackLevel < $past(maskQ)) else $error("AST_ACK_BELOW_OLD_MASK"); // R2
  AST_NO_INHIBITED: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> ackLevel != INHIBIT_LEVEL) else $error("AST_NO_INHIBITED"); // R4
  AST_MASK_TRACKS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |-> maskQ == ackLevel) else $error("AST_MASK_TRACKS_ACK"); // R7
  AST_UPPER_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (!ackPulse && $past(maskQ) >= 5'd16) |-> maskQ >= 5'd16) else $error("AST_UPPER_FLOOR"); // R8
  AST_BYPASS_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    bypassAck |-> ($stable(maskQ) && !ackPulse)) else $error("AST_BYPASS_HOLDS_MASK"); // R10

endmodule

// File: rtl/ilm_gate.sv
module ilm_gate
  import ilm_pkg::*;
#(
  parameter int NUM_REQ = 4,
  localparam int ID_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_REQ-1:0]     reqValid,
  input  logic [NUM_REQ*5-1:0]   reqLevel,
  input  logic                   intEnable,
  input  logic                   nmiReq,
  input  logic                   stepReq,
  input  logic                   bypassReq,
  input  logic                   maskWrEn,
  input  logic [4:0]             maskWrData,
  output logic                   ackPulse,
  output logic [4:0]             ackLevel,
  output logic [1:0]             ackKind,
  output logic [ID_W-1:0]        ackId,
  output logic                   bypassAck,
  output logic [4:0]             maskLevel
);

  ctrlStrobes_t ctrl;
  logic bestValid;
  logic nmiOk;
  logic stepOk;

  ilm_control u_control (
    .bypassReq (bypassReq),
    .stepReq   (stepReq),
    .nmiReq    (nmiReq),
    .maskWrEn  (maskWrEn),
    .bestValid (bestValid),
    .nmiOk     (nmiOk),
    .stepOk    (stepOk),
    .ctrl      (ctrl)
  );

  ilm_datapath #(
    .NUM_REQ (NUM_REQ),
    .ID_W    (ID_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLevel   (reqLevel),
    .intEnable  (intEnable),
    .maskWrData (maskWrData),
    .ctrl       (ctrl),
    .bestValid  (bestValid),
    .nmiOk      (nmiOk),
    .stepOk     (stepOk),
    .ackPulse   (ackPulse),
    .ackLevel   (ackLevel),
    .ackKind    (ackKind),
    .ackId      (ackId),
    .bypassAck  (bypassAck),
    .maskQ      (maskLevel)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(ackPulse && bypassAck)) else $error("AST_ONE_STROBE"); // R10

endmodule

// File: tb/ilm_gate_tb.sv
`timescale 1ns/1ps
module ilm_gate_tb;

  localparam int NUM_REQ = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_REQ-1:0] reqValid = '0;
  logic [NUM_REQ*5-1:0] reqLevel = '0;
  logic intEnable = 1'b0;
  logic nmiReq = 1'b0;
  logic stepReq = 1'b0;
  logic bypassReq = 1'b0;
  logic maskWrEn = 1'b0;
  logic [4:0] maskWrData = '0;
  logic ackPulse;
  logic [4:0] ackLevel;
  logic [1:0] ackKind;
  logic [1:0] ackId;
  logic bypassAck;
  logic [4:0] maskLevel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ilm_gate #(.NUM_REQ(NUM_REQ)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLevel(reqLevel),
    .intEnable(intEnable), .nmiReq(nmiReq), .stepReq(stepReq),
    .bypassReq(bypassReq), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .ackPulse(ackPulse), .ackLevel(ackLevel), .ackKind(ackKind),
    .ackId(ackId), .bypassAck(bypassAck), .maskLevel(maskLevel)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearInputs();
    reqValid = '0; reqLevel = '0; intEnable = 1'b0; nmiReq = 1'b0;
    stepReq = 1'b0; bypassReq = 1'b0; maskWrEn = 1'b0; maskWrData = '0;
  endtask

  // Inputs set now take effect on the next edge; sample 1 ns after it.
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeMask(input logic [4:0] v);
    maskWrEn = 1'b1; maskWrData = v;
    tick();
    clearInputs();
  endtask

  task automatic setReq(input int idx, input logic [4:0] lvl);
    reqValid[idx] = 1'b1;
    reqLevel[idx*5 +: 5] = lvl;
  endtask

  task automatic t_reset();
    check("R1", "mask", maskLevel, 15);
    check("R1", "ackPulse", ackPulse, 0);
    check("R1", "bypassAck", bypassAck, 0);
  endtask

  task automatic t_maskable();
    setReq(2, 5'd20); intEnable = 1'b1;
    tick();
    check("R2", "ack at mask 15", ackPulse, 0);
    clearInputs();
    writeMask(5'd31);
    check("R8", "write 31 below 16", maskLevel, 31);
    setReq(2, 5'd20); intEnable = 1'b0;
    tick();
    check("R2", "ack when disabled", ackPulse, 0);
    check("R2", "mask when disabled", maskLevel, 31);
    intEnable = 1'b1;
    tick();
    check("R2", "ack", ackPulse, 1);
    check("R2", "level", ackLevel, 20);
    check("R2", "kind", ackKind, 0);
    check("R2", "id", ackId, 2);
    check("R7", "mask loaded", maskLevel, 20);
    clearInputs();
    tick();
    check("R2", "strobe one cycle", ackPulse, 0);
  endtask

  task automatic t_priority();
    writeMask(5'd31);
    setReq(0, 5'd25); setReq(1, 5'd18); setReq(2, 5'd18); setReq(3, 5'd22);
    intEnable = 1'b1;
    tick();
    check("R3", "level", ackLevel, 18);
    check("R3", "tie id", ackId, 1);
    check("R7", "mask", maskLevel, 18);
    clearInputs();
  endtask

  task automatic t_inhibit();
    writeMask(5'd31);
    setReq(3, 5'd31); intEnable = 1'b1;
    tick();
    check("R4", "level 31 ack", ackPulse, 0);
    check("R4", "mask held", maskLevel, 31);
    clearInputs();
  endtask

  task automatic t_nmi();
    nmiReq = 1'b1; setReq(0, 5'd16); intEnable = 1'b0;
    tick();
    check("R5", "ack", ackPulse, 1);
    check("R5", "kind", ackKind, 1);
    check("R5", "level", ackLevel, 15);
    check("R7", "mask", maskLevel, 15);
    clearInputs();
    nmiReq = 1'b1;
    tick();
    check("R5", "ack at mask 15", ackPulse, 0);
    clearInputs();
  endtask

  task automatic t_write();
    writeMask(5'd3);
    check("R8", "write 3 below 16", maskLevel, 3);
    writeMask(5'd31);
    check("R8", "raise to 31", maskLevel, 31);
    writeMask(5'd7);
    check("R8", "write 7 at 31", maskLevel, 23);
    writeMask(5'd2);
    check("R8", "write 2 at 23", maskLevel, 18);
  endtask

  task automatic t_step();
    stepReq = 1'b1; nmiReq = 1'b1; intEnable = 1'b0;
    tick();
    check("R6", "ack", ackPulse, 1);
    check("R6", "kind", ackKind, 2);
    check("R6", "level", ackLevel, 4);
    check("R6", "mask", maskLevel, 4);
    clearInputs();
    stepReq = 1'b1;
    tick();
    check("R6", "ack at mask 4", ackPulse, 0);
    clearInputs();
  endtask

  task automatic t_collision();
    writeMask(5'd31);
    setReq(1, 5'd20); intEnable = 1'b1; maskWrEn = 1'b1; maskWrData = 5'd25;
    tick();
    check("R9", "ack", ackPulse, 1);
    check("R9", "mask takes level", maskLevel, 20);
    clearInputs();
  endtask

  task automatic t_bypass();
    bypassReq = 1'b1; nmiReq = 1'b1; maskWrEn = 1'b1; maskWrData = 5'd28;
    tick();
    check("R10", "bypassAck", bypassAck, 1);
    check("R10", "no ack", ackPulse, 0);
    check("R10", "mask held", maskLevel, 20);
    clearInputs();
    tick();
    check("R10", "bypass one cycle", bypassAck, 0);
    check("R10", "mask still held", maskLevel, 20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    tick();
    t_reset();
    t_maskable();
    t_priority();
    t_inhibit();
    t_nmi();
    t_write();
    t_step();
    t_collision();
    t_bypass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule